// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

A binary counter that steps on two separate count pulse inputs: a rising edge on the up pulse adds one and a rising edge on the down pulse subtracts one, with wrap-around at both ends. A free-running system clock samples every input through a two-flop synchroniser, and edge detectors on the synchronised up and down levels produce the count events. A clear input and an active-low parallel load input take precedence over counting.

Two active-low terminal outputs make stages chainable without glue logic. The carry output copies the low phase of the synchronised up pulse while the count sits at its maximum. The borrow output does the same for the down pulse while the count sits at zero. Wiring a stage's carry to the next stage's up pulse and its borrow to the next stage's down pulse gives a wider counter, with every stage on the same system clock.

Top module: `pulse_updown_counter`

## Requirements
- R1: A synchronised 0-to-1 transition on `up_pulse` alone adds one to `q` modulo 2^WIDTH (maximum wraps to 0). A level change driven before clock edge k shows on `q` after edge k+2.
- R2: A synchronised 0-to-1 transition on `dn_pulse` alone subtracts one from `q` modulo 2^WIDTH (0 wraps to the maximum).
- R3: While the synchronised `clr` is 1, `q` is forced to 0 whatever `ld_n`, `din` and the count pulses do.
- R4: While the synchronised `clr` is 0 and `ld_n` is 0, `q` takes the synchronised `din`, whatever the count pulses do.
- R5: With clear and load inactive and no count edge (both pulses held at 1), `q` keeps its value.
- R6: Rising edges on both count pulses in the same system cycle cancel, and `q` keeps its value.
- R7: `carry_n` is 0 exactly when `q` is at its maximum and the synchronised `up_pulse` is 0; otherwise it is 1, so it rises together with the up pulse.
- R8: `borrow_n` is 0 exactly when `q` is 0 and the synchronised `dn_pulse` is 0; otherwise it is 1.
- R9: A count pulse held at 0 through a clear or a load, and raised after the release, is counted once.
- R10: Synchronous active-high `rst` sets `q` to 0, `carry_n` and `borrow_n` to 1, and treats the pulses as having been high, so pulses still high after reset produce no event.
- R11: Two stages joined carry-to-up and borrow-to-down count as one 2*WIDTH-bit counter in both directions, across wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| up_pulse | input | 1 | Count-up pulse, counts on its rising edge |
| dn_pulse | input | 1 | Count-down pulse, counts on its rising edge |
| clr | input | 1 | Clear, active high |
| ld_n | input | 1 | Parallel load, active low |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal output for up counting |
| borrow_n | output | 1 | Active-low terminal output for down counting |

## Verification
The assertions take for granted that at most one count pulse is in use at a time, the idle one held at 1, so that the carry and borrow outputs are never low together. The directed stimulus keeps to that by driving only one pulse low at a time, except for the deliberate same-cycle pair used for the cancel rule. Cascaded stage inputs respect it by construction, since the lower stage cannot be at zero and at its maximum at once. Pulse phases are held four system cycles so that the synchroniser never misses a level.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_INC,
        OP_DEC
    } op_e;

    typedef struct packed {
        logic clr;
        logic ld_n;
        logic up;
        logic dn;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{clr: 1'b0, ld_n: 1'b1, up: 1'b1, dn: 1'b1};

    // Priority: clear, then load, then a single count edge.
    function automatic op_e pick_op(input ctl_t c, input logic up_ev, input logic dn_ev);
        op_e op;
        if (c.clr)                   op = OP_CLEAR;
        else if (!c.ld_n)            op = OP_LOAD;
        else if (up_ev && !dn_ev)    op = OP_INC;
        else if (dn_ev && !up_ev)    op = OP_DEC;
        else                         op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                pipe[i] <= RST_VAL;
            else if (i == 0)
                pipe[i] <= d;
            else
                pipe[i] <= pipe[(i == 0) ? 0 : i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/updn_edge.sv
module updn_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/updn_core.sv
module updn_core
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= din;
                OP_INC:   q <= q + ONE;
                OP_DEC:   q <= q - ONE;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = '1;

    assign carry_n  = !((q == TOP) && !up_lvl);
    assign borrow_n = !((q == '0)  && !dn_lvl);
endmodule

// File: rtl/pulse_updown_counter.sv
module pulse_updown_counter
    import updn_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_pulse,
    input  logic             dn_pulse,
    input  logic             clr,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam int CW = $bits(ctl_t);
    localparam int VW = CW + WIDTH;
    localparam logic [VW-1:0] SYNC_RST = {CTL_IDLE, {WIDTH{1'b0}}};

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [WIDTH-1:0] din_s;
    logic [VW-1:0]    sync_out;
    logic [1:0]       rise;
    logic             up_rise;
    logic             dn_rise;
    op_e              op;

    always_comb begin
        ctl_raw.clr  = clr;
        ctl_raw.ld_n = ld_n;
        ctl_raw.up   = up_pulse;
        ctl_raw.dn   = dn_pulse;
    end

    updn_sync #(.W(VW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ctl_raw, din}),
        .q   (sync_out)
    );

    assign ctl_s = ctl_t'(sync_out[VW-1:WIDTH]);
    assign din_s = sync_out[WIDTH-1:0];

    updn_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({ctl_s.up, ctl_s.dn}),
        .rise (rise)
    );

    assign up_rise = rise[1];
    assign dn_rise = rise[0];
    assign op      = pick_op(ctl_s, up_rise, dn_rise);

    updn_core #(.WIDTH(WIDTH)) u_core (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (din_s),
        .q   (q)
    );

    updn_term #(.WIDTH(WIDTH)) u_term (
        .q        (q),
        .up_lvl   (ctl_s.up),
        .dn_lvl   (ctl_s.dn),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );
endmodule

// File: rtl/pulse_updown_counter_chk.sv
module pulse_updown_counter_chk
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] q,
    input logic             carry_n,
    input logic             borrow_n,
    input ctl_t             ctl_s,
    input logic [WIDTH-1:0] din_s,
    input logic             up_rise,
    input logic             dn_rise
);
    localparam logic [WIDTH-1:0] TOP = '1;

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_s.clr |=> (q == '0));

    a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
        (!ctl_s.clr && !ctl_s.ld_n) |=> (q == $past(din_s)));

    a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
        (!ctl_s.clr && ctl_s.ld_n && up_rise && !dn_rise)
        |=> (q == WIDTH'($past(q) + 1'b1)));

    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (!ctl_s.clr && ctl_s.ld_n && dn_rise && !up_rise)
        |=> (q == WIDTH'($past(q) - 1'b1)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl_s.clr && ctl_s.ld_n && !up_rise && !dn_rise) |=> $stable(q));

    a_r6_cancel: assert property (@(posedge clk) disable iff (rst)
        (!ctl_s.clr && ctl_s.ld_n && up_rise && dn_rise) |=> $stable(q));

    a_r7_carry_at_top: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> (q == TOP));

    a_r8_borrow_at_zero: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> (q == '0));
endmodule

bind pulse_updown_counter pulse_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .q        (q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .ctl_s    (ctl_s),
    .din_s    (din_s),
    .up_rise  (up_rise),
    .dn_rise  (dn_rise)
);

// File: tb/tb_pulse_updown_counter.sv
module tb_pulse_updown_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up0 = 1'b1;
    logic       dn0 = 1'b1;
    logic       clr = 1'b0;
    logic       ld_n = 1'b1;
    logic [7:0] din8 = 8'h00;
    logic [3:0] q0, q1;
    logic       c0, b0, c1, b1;

    int checks = 0;
    int errors = 0;
    int exp8   = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pulse_updown_counter #(.WIDTH(4)) dut (
        .clk(clk), .rst(rst), .up_pulse(up0), .dn_pulse(dn0),
        .clr(clr), .ld_n(ld_n), .din(din8[3:0]),
        .q(q0), .carry_n(c0), .borrow_n(b0)
    );

    pulse_updown_counter #(.WIDTH(4)) dut_hi (
        .clk(clk), .rst(rst), .up_pulse(c0), .dn_pulse(b0),
        .clr(clr), .ld_n(ld_n), .din(din8[7:4]),
        .q(q1), .carry_n(c1), .borrow_n(b1)
    );

    // Behavioural reference: history of sampled inputs per stage.
    bit h_clr [2][4];
    bit h_ld  [2][4];
    bit h_up  [2][4];
    bit h_dn  [2][4];
    int h_d   [2][4];
    int mcnt  [2];

    function automatic bit m_carry(int s);
        return !(mcnt[s] == 15 && !h_up[s][1]);
    endfunction

    function automatic bit m_borrow(int s);
        return !(mcnt[s] == 0 && !h_dn[s][1]);
    endfunction

    task automatic m_step(int s, bit c, bit l, bit u, bit d, int v);
        bit ue, de;
        for (int i = 3; i > 0; i--) begin
            h_clr[s][i] = h_clr[s][i-1]; h_ld[s][i] = h_ld[s][i-1];
            h_up[s][i]  = h_up[s][i-1];  h_dn[s][i] = h_dn[s][i-1];
            h_d[s][i]   = h_d[s][i-1];
        end
        h_clr[s][0] = c; h_ld[s][0] = l; h_up[s][0] = u; h_dn[s][0] = d; h_d[s][0] = v;
        ue = h_up[s][2] && !h_up[s][3];
        de = h_dn[s][2] && !h_dn[s][3];
        if (h_clr[s][2])      mcnt[s] = 0;
        else if (!h_ld[s][2]) mcnt[s] = h_d[s][2];
        else if (ue && !de)   mcnt[s] = (mcnt[s] + 1) % 16;
        else if (de && !ue)   mcnt[s] = (mcnt[s] + 15) % 16;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                mcnt[s] = 0;
                for (int i = 0; i < 4; i++) begin
                    h_clr[s][i] = 0; h_ld[s][i] = 1; h_up[s][i] = 1;
                    h_dn[s][i] = 1;  h_d[s][i] = 0;
                end
            end
        end else begin
            bit hc, hb;
            hc = m_carry(0);
            hb = m_borrow(0);
            m_step(1, clr, ld_n, hc, hb, int'(din8[7:4]));
            m_step(0, clr, ld_n, up0, dn0, int'(din8[3:0]));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R11 model q stage0 (R1 R2 R3 R4)", int'(q0), mcnt[0]);
            chk("R11 model q stage1", int'(q1), mcnt[1]);
            chk("R7 model carry stage0", int'(c0), int'(m_carry(0)));
            chk("R8 model borrow stage0", int'(b0), int'(m_borrow(0)));
            chk("R7 model carry stage1", int'(c1), int'(m_carry(1)));
            chk("R8 model borrow stage1", int'(b1), int'(m_borrow(1)));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(bit go_up, int n);
        for (int i = 0; i < n; i++) begin
            if (go_up) up0 = 1'b0; else dn0 = 1'b0;
            cyc(4);
            if (go_up) up0 = 1'b1; else dn0 = 1'b1;
            cyc(4);
        end
        cyc(10);
    endtask

    task automatic load8(int v);
        din8 = 8'(v);
        ld_n = 1'b0;
        cyc(4);
        ld_n = 1'b1;
        cyc(10);
    endtask

    function automatic int both();
        return int'({q1, q0});
    endfunction

    initial begin
        cyc(3);
        rst = 1'b0;
        chk("R10 reset q", both(), 0);
        chk("R10 reset carry", int'(c0), 1);
        chk("R10 reset borrow", int'(b0), 1);
        cyc(6);
        chk("R10 high pulses after reset give no event", both(), 0);

        pulses(1, 5);
        exp8 = 5;
        chk("R1 five up pulses", both(), exp8);

        // Load with down pulse held low, then release it.
        dn0 = 1'b0;
        cyc(2);
        load8(8'hFD);
        chk("R4 load ignores low down pulse", both(), 8'hFD);
        dn0 = 1'b1;
        cyc(10);
        chk("R9 down edge after load counts", both(), 8'hFC);

        pulses(1, 4);
        chk("R11 up wrap of combined value", both(), 0);
        pulses(0, 1);
        chk("R2 down wrap via borrow", both(), 8'hFF);

        load8(8'h0F);
        up0 = 1'b0;
        cyc(4);
        chk("R7 carry low at top with up low", int'(c0), 0);
        up0 = 1'b1;
        cyc(10);
        chk("R7 carry back high", int'(c0), 1);
        chk("R11 carry stepped upper stage", both(), 8'h10);

        dn0 = 1'b0;
        cyc(4);
        chk("R8 borrow low at zero with down low", int'(b0), 0);
        dn0 = 1'b1;
        cyc(10);
        chk("R11 borrow stepped upper stage", both(), 8'h0F);

        load8(8'h55);
        cyc(20);
        chk("R5 hold with pulses high", both(), 8'h55);

        up0 = 1'b0; dn0 = 1'b0;
        cyc(4);
        up0 = 1'b1; dn0 = 1'b1;
        cyc(10);
        chk("R6 simultaneous edges cancel", both(), 8'h55);

        // Clear beats load and counting.
        din8 = 8'hAA; ld_n = 1'b0; clr = 1'b1;
        cyc(4);
        up0 = 1'b0; cyc(4); up0 = 1'b1; cyc(4);
        chk("R3 clear overrides load and count", both(), 0);
        clr = 1'b0;
        cyc(6);
        chk("R4 load after clear release", both(), 8'hAA);
        ld_n = 1'b1;
        cyc(4);

        // Up held low through a clear, raised after release.
        up0 = 1'b0; clr = 1'b1;
        cyc(6);
        clr = 1'b0;
        cyc(6);
        chk("R3 clear with up low", both(), 0);
        up0 = 1'b1;
        cyc(10);
        chk("R9 up edge after clear counts", both(), 1);

        exp8 = 1;
        pulses(1, 300);
        exp8 = (exp8 + 300) % 256;
        chk("R1 long up sweep", both(), exp8);
        pulses(0, 310);
        exp8 = (exp8 + 256 * 2 - 310) % 256;
        chk("R2 long down sweep", both(), exp8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule